// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog with two countdown stages in series, seen by software through a small memory-mapped register bus. While the watchdog runs, stage 1 counts down from its preload. When it runs out it sets an interrupt-pending status and can drive an interrupt line. Stage 2 then counts down from its own preload. When stage 2 runs out it latches a sticky timeout flag, can pulse a reset output, and counting starts again at stage 1. Software keeps the system alive by restarting the counters before stage 2 expires.

The two preload registers and the restart/flag-clear register are guarded. A write to one of them is accepted only after a two-write key sequence has been written to the restart register, and one key opens the gate for exactly one write. A control register holds the run enable, a mode select and a sticky lock. A configuration register holds the reset-output disable, the tick-rate select and the interrupt type. Both of these registers become read-only once the lock bit has been set. A prescaler divides the clock down to the countdown tick.

Top module: `wdt2_top`

## Requirements
- R1: Writing 0x0080 and then 0x0086 (the low 16 bits of the write, after byte-strobe masking) to the restart register at 0x0C opens the gate for exactly one write to 0x00, 0x04 or 0x0C. After that single write the gate is closed again.
- R2: While the key sequence is in progress, a write to 0x0C whose low 16 bits are not the expected key value returns the sequence to its start. For example, 0x80, 0x80, 0x86 does not open the gate.
- R3: Writes to the preloads (stage 1 at 0x00, stage 2 at 0x04) are ignored while the gate is closed. Each preload is CNT_W bits wide and reads back zero-extended.
- R4: A gated write to 0x0C with bit 8 set restarts stage 1 from the stage-1 preload, clears the pending status and restarts the prescaler. The same write without the key has no effect.
- R5: Once running, stage 1 expires on its (preload+1)-th tick. Expiry sets bit 0 of the status register at 0x08 and loads stage 2 from the stage-2 preload. irq_o is high while that bit is set, unless the interrupt type (config bits 1:0) is 2'b11.
- R6: Stage 2 expires on its (preload+1)-th tick. Expiry sets the timeout flag (bit 9 of 0x0C), pulses wdt_rst_o high for one cycle unless config bit 5 is 1, and restarts stage 1.
- R7: The timeout flag is cleared only by a gated write to 0x0C with bit 9 set, or by rst_n. The watchdog's own reset pulse does not clear it.
- R8: The counters run only when control bit 1 (enable) is 1 and control bit 2 (mode) is 0. Otherwise both counters hold their preloads, the pending status is cleared and neither output asserts.
- R9: Control bit 0 is a lock. Once it is 1, writes to the control register (0x10) and the config register (0x14) are ignored until rst_n.
- R10: Config bit 2 at 0 gives one tick every 2^SLOW_LOG2 clocks. At 1 it gives one tick every 2^FAST_LOG2 clocks. Only config bits 5, 2, 1 and 0 are stored.
- R11: Writing 1 to bit 0 of the status register clears the pending status and needs no key. A stage-1 expiry in the same cycle wins.
- R12: A new preload value does not change a running count. It is used only at the next restart, at the next stage transition, or while the watchdog is stopped.
- R13: Byte strobes mask the write data byte by byte. A write with all strobes low is ignored entirely, including by the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| we_i | input | 1 | Write strobe for one cycle |
| addr_i | input | AW | Byte address of the register |
| wdata_i | input | DW | Write data |
| wstrb_i | input | DW/8 | Byte strobes for the write |
| rdata_o | output | DW | Read data for addr_i (combinational) |
| irq_o | output | 1 | Stage-1 interrupt |
| wdt_rst_o | output | 1 | One-cycle reset pulse on stage-2 expiry |

## Verification
The hardest situations to reach from the bus are the ones where several things collide: a gate consumed by one write while a second guarded write follows, a key sequence broken by a repeated first key or by a strobe-less write, and a flag-clear landing while counting is in progress. The stimulus reaches them with scripted key sequences, including broken ones, and then reads back the guarded registers. Long keepalive loops run with and without the key, so that both the absence and the arrival of the interrupt are observed. The tick rate is made fast enough through parameters that full two-stage expiries, with both tick rates, occur within a short run, and the cycle at which each output first rises is measured.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_ARMED = 2'd1,
        UL_OPEN  = 2'd2
    } ul_state_e;

    localparam logic [4:0] OFS_PRE1   = 5'h00;
    localparam logic [4:0] OFS_PRE2   = 5'h04;
    localparam logic [4:0] OFS_STAT   = 5'h08;
    localparam logic [4:0] OFS_RELOAD = 5'h0C;
    localparam logic [4:0] OFS_CTRL   = 5'h10;
    localparam logic [4:0] OFS_CFG    = 5'h14;

    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;

    localparam logic [5:0] CFG_KEEP = 6'b10_0111;
    localparam logic [1:0] IRQ_OFF  = 2'b11;

endpackage

// File: rtl/wdt2_unlock.sv
module wdt2_unlock
    import wdt2_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic        prot_wr,
    input  logic [15:0] key_val,
    output logic        open_o
);

    ul_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UL_IDLE:  if (key_wr) st_d = (key_val == KEY_FIRST) ? UL_ARMED : UL_IDLE;
            UL_ARMED: if (key_wr) st_d = (key_val == KEY_SECOND) ? UL_OPEN : UL_IDLE;
            UL_OPEN:  if (key_wr || prot_wr) st_d = UL_IDLE;
            default:  st_d = UL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    assign open_o = (st_q == UL_OPEN);

endmodule

// File: rtl/wdt2_prescale.sv
module wdt2_prescale #(
    parameter int SLOW_LOG2 = 15,
    parameter int FAST_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic fast_sel,
    output logic tick_o
);

    logic [SLOW_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || clear) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run && (fast_sel ? (&cnt_q[FAST_LOG2-1:0]) : (&cnt_q));

endmodule

// File: rtl/wdt2_stages.sv
module wdt2_stages #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic             exp1_o,
    output logic             exp2_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             second;
    } stage_t;

    stage_t s_d, s_q;
    logic   step, at_zero;

    assign step    = active && !restart && tick;
    assign at_zero = (s_q.cnt == '0);
    assign exp1_o  = step && at_zero && !s_q.second;
    assign exp2_o  = step && at_zero && s_q.second;

    always_comb begin
        s_d = s_q;
        if (!active || restart) begin
            s_d.cnt    = pre1;
            s_d.second = 1'b0;
        end else if (tick) begin
            if (!at_zero) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else if (!s_q.second) begin
                s_d.cnt    = pre2;
                s_d.second = 1'b1;
            end else begin
                s_d.cnt    = pre1;
                s_d.second = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int SLOW_LOG2 = 15,
    parameter int FAST_LOG2 = 12,
    parameter int AW        = 5,
    parameter int DW        = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [DW/8-1:0] wstrb_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o,
    output logic            wdt_rst_o
);

    localparam int NB = DW / 8;

    typedef struct packed {
        logic [CNT_W-1:0] pre1;
        logic [CNT_W-1:0] pre2;
        logic [2:0]       ctrl;
        logic [5:0]       cfg;
        logic             pend;
        logic             flag;
        logic             rst;
    } regs_t;

    regs_t r_d, r_q;

    logic [DW-1:0] bmask, wm;
    logic wr_any, hit_pre1, hit_pre2, hit_stat, hit_reload, hit_ctrl, hit_cfg;
    logic wr_pre, wr_reload, ul_open, active, restart, flag_clr;
    logic tick, exp1, exp2;

    for (genvar gb = 0; gb < NB; gb++) begin : g_mask
        assign bmask[8*gb +: 8] = {8{wstrb_i[gb]}};
    end

    assign wm = wdata_i & bmask;

    if (CNT_W < DW) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^wm[DW-1:CNT_W];
    end

    assign wr_any     = we_i && (|wstrb_i);
    assign hit_pre1   = (addr_i == AW'(OFS_PRE1));
    assign hit_pre2   = (addr_i == AW'(OFS_PRE2));
    assign hit_stat   = (addr_i == AW'(OFS_STAT));
    assign hit_reload = (addr_i == AW'(OFS_RELOAD));
    assign hit_ctrl   = (addr_i == AW'(OFS_CTRL));
    assign hit_cfg    = (addr_i == AW'(OFS_CFG));
    assign wr_pre     = wr_any && (hit_pre1 || hit_pre2);
    assign wr_reload  = wr_any && hit_reload;

    assign active   = r_q.ctrl[1] && !r_q.ctrl[2];
    assign restart  = wr_reload && ul_open && wm[8];
    assign flag_clr = wr_reload && ul_open && wm[9];

    wdt2_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (wr_reload),
        .prot_wr (wr_pre),
        .key_val (wm[15:0]),
        .open_o  (ul_open)
    );

    wdt2_prescale #(
        .SLOW_LOG2 (SLOW_LOG2),
        .FAST_LOG2 (FAST_LOG2)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .clear    (restart),
        .fast_sel (r_q.cfg[2]),
        .tick_o   (tick)
    );

    wdt2_stages #(
        .CNT_W (CNT_W)
    ) u_stages (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .tick    (tick),
        .restart (restart),
        .pre1    (r_q.pre1),
        .pre2    (r_q.pre2),
        .exp1_o  (exp1),
        .exp2_o  (exp2)
    );

    always_comb begin
        r_d = r_q;
        if (wr_pre && ul_open) begin
            if (hit_pre1) r_d.pre1 = (r_q.pre1 & ~bmask[CNT_W-1:0]) | wm[CNT_W-1:0];
            else          r_d.pre2 = (r_q.pre2 & ~bmask[CNT_W-1:0]) | wm[CNT_W-1:0];
        end
        if (wr_any && wstrb_i[0] && !r_q.ctrl[0]) begin
            if (hit_ctrl) r_d.ctrl = wdata_i[2:0];
            if (hit_cfg)  r_d.cfg  = wdata_i[5:0] & CFG_KEEP;
        end
        if (!active || restart)             r_d.pend = 1'b0;
        else if (exp1)                      r_d.pend = 1'b1;
        else if (wr_any && hit_stat && wm[0]) r_d.pend = 1'b0;
        if (exp2)          r_d.flag = 1'b1;
        else if (flag_clr) r_d.flag = 1'b0;
        r_d.rst = exp2 && !r_q.cfg[5];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (hit_pre1)   rdata_o = DW'(r_q.pre1);
        if (hit_pre2)   rdata_o = DW'(r_q.pre2);
        if (hit_stat)   rdata_o = DW'(r_q.pend);
        if (hit_reload) rdata_o = DW'({r_q.flag, 9'd0});
        if (hit_ctrl)   rdata_o = DW'(r_q.ctrl);
        if (hit_cfg)    rdata_o = DW'(r_q.cfg);
    end

    assign irq_o     = r_q.pend && active && (r_q.cfg[1:0] != IRQ_OFF);
    assign wdt_rst_o = r_q.rst;

endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             lock,
    input logic             flag,
    input logic             cfg_rst_off,
    input logic             ul_open,
    input logic             prot_wr,
    input logic [CNT_W-1:0] pre1,
    input logic [CNT_W-1:0] pre2,
    input logic             irq_o,
    input logic             wdt_rst_o
);

    // R1: one guarded write closes the gate again
    p_relock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ul_open && prot_wr) |=> !ul_open);

    // R3: preloads change only in a cycle where the gate was open
    p_pre_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ul_open) |-> ($stable(pre1) && $stable(pre2)));

    // R6: reset output is a single-cycle pulse
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    // R6: flag rises together with the pulse unless the output is disabled
    p_flag_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (wdt_rst_o || $past(cfg_rst_off)));

    // R8: a stopped watchdog drives neither output
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> (!irq_o && !wdt_rst_o));

    // R9: the lock never clears while out of reset
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock) |-> lock);

endmodule

bind wdt2_top wdt2_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .lock        (r_q.ctrl[0]),
    .flag        (r_q.flag),
    .cfg_rst_off (r_q.cfg[5]),
    .ul_open     (ul_open),
    .prot_wr     (wr_pre || wr_reload),
    .pre1        (r_q.pre1),
    .pre2        (r_q.pre2),
    .irq_o       (irq_o),
    .wdt_rst_o   (wdt_rst_o)
);

// File: tb/wdt2_top_tb_top.sv
module wdt2_top_tb_top;

    localparam int CNT_W = 20;
    localparam int SLOW  = 4;
    localparam int FAST  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = 5'h00;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic [31:0] rdata;
    logic        irq, wrst;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdt2_top #(.CNT_W(CNT_W), .SLOW_LOG2(SLOW), .FAST_LOG2(FAST)) dut_i (
        .clk(clk), .rst_n(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .wstrb_i(wstrb), .rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
    );

    // behavioural reference model
    logic [19:0] m_pre1, m_pre2, m_cnt;
    logic [2:0]  m_ctrl;
    logic [5:0]  m_cfg;
    logic        m_pend, m_flag, m_rst, m_second;
    int          m_key, m_psc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre1 = 0; m_pre2 = 0; m_cnt = 0; m_ctrl = 0; m_cfg = 0;
            m_pend = 0; m_flag = 0; m_rst = 0; m_second = 0; m_key = 0; m_psc = 0;
        end else begin
            logic [31:0] msk, w;
            logic wr, run, tk, opn, rs, e1, e2;
            int div;
            msk = {{8{wstrb[3]}}, {8{wstrb[2]}}, {8{wstrb[1]}}, {8{wstrb[0]}}};
            w   = wdata & msk;
            wr  = we && (wstrb != 0);
            run = m_ctrl[1] && !m_ctrl[2];
            div = m_cfg[2] ? (1 << FAST) : (1 << SLOW);
            tk  = run && ((m_psc % div) == div - 1);
            opn = (m_key == 2);
            rs  = wr && addr == 5'h0C && opn && w[8];
            e1 = 0; e2 = 0;
            if (!run || rs) begin
                m_cnt = m_pre1; m_second = 0;
            end else if (tk) begin
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                else if (!m_second) begin e1 = 1; m_second = 1; m_cnt = m_pre2; end
                else begin e2 = 1; m_second = 0; m_cnt = m_pre1; end
            end
            m_psc = (!run || rs) ? 0 : (m_psc + 1) % (1 << SLOW);
            if (!run || rs) m_pend = 0;
            else if (e1) m_pend = 1;
            else if (wr && addr == 5'h08 && w[0]) m_pend = 0;
            if (e2) m_flag = 1;
            else if (wr && addr == 5'h0C && opn && w[9]) m_flag = 0;
            m_rst = e2 && !m_cfg[5];
            if (wr && opn && addr == 5'h00) m_pre1 = (m_pre1 & ~msk[19:0]) | w[19:0];
            if (wr && opn && addr == 5'h04) m_pre2 = (m_pre2 & ~msk[19:0]) | w[19:0];
            if (wr && wstrb[0] && !m_ctrl[0]) begin
                if (addr == 5'h10) m_ctrl = wdata[2:0];
                if (addr == 5'h14) m_cfg = wdata[5:0] & 6'h27;
            end
            if (wr && addr == 5'h0C) begin
                if (m_key == 0)      m_key = (w[15:0] == 16'h0080) ? 1 : 0;
                else if (m_key == 1) m_key = (w[15:0] == 16'h0086) ? 2 : 0;
                else                 m_key = 0;
            end else if (wr && opn && (addr == 5'h00 || addr == 5'h04)) begin
                m_key = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] er;
            string t;
            logic ei;
            ei = m_pend && m_ctrl[1] && !m_ctrl[2] && (m_cfg[1:0] != 2'b11);
            chk("R5 irq_o model", {31'd0, irq}, {31'd0, ei});
            chk("R6 wdt_rst_o model", {31'd0, wrst}, {31'd0, m_rst});
            case (addr)
                5'h00:   begin er = {12'd0, m_pre1}; t = "R3 pre1 read"; end
                5'h04:   begin er = {12'd0, m_pre2}; t = "R3 pre2 read"; end
                5'h08:   begin er = {31'd0, m_pend}; t = "R11 status read"; end
                5'h0C:   begin er = {22'd0, m_flag, 9'd0}; t = "R7 flag read"; end
                5'h10:   begin er = {29'd0, m_ctrl}; t = "R9 ctrl read"; end
                5'h14:   begin er = {26'd0, m_cfg}; t = "R10 cfg read"; end
                default: begin er = 0; t = "R3 unmapped read"; end
            endcase
            chk(t, rdata, er);
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        we = 1; addr = a; wdata = d; wstrb = s;
        @(posedge clk); #1;
        we = 0; wstrb = 0;
    endtask

    task automatic key();
        wr(5'h0C, 32'h80);
        wr(5'h0C, 32'h86);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 1000) begin @(posedge clk); #1; n++; end
    endtask

    task automatic wait_rst(output int n);
        n = 0;
        while (!wrst && n < 1000) begin @(posedge clk); #1; n++; end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle(1);
        // reset state
        rd(5'h0C, 0, "R7 reset flag");
        rd(5'h10, 0, "R9 reset ctrl");
        chk("R8 reset irq", {31'd0, irq}, 0);
        // R3: preload write without the key is ignored
        wr(5'h00, 32'h5);
        rd(5'h00, 0, "R3 ungated pre1");
        key(); wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'h000F_FFFF, "R3 pre1 width");
        // R1: one write per key
        key(); wr(5'h00, 32'h3); wr(5'h04, 32'h7);
        rd(5'h00, 32'h3, "R1 first write taken");
        rd(5'h04, 32'h0, "R1 second write dropped");
        // R2: broken sequences
        wr(5'h0C, 32'h80); wr(5'h0C, 32'h80); wr(5'h0C, 32'h86); wr(5'h04, 32'h2);
        rd(5'h04, 0, "R2 repeated first key");
        wr(5'h0C, 32'h80); wr(5'h0C, 32'h55); wr(5'h0C, 32'h86); wr(5'h04, 32'h2);
        rd(5'h04, 0, "R2 wrong second key");
        key(); wr(5'h04, 32'h2);
        rd(5'h04, 32'h2, "R1 gated pre2");
        // R13: byte strobes
        key(); wr(5'h04, 32'h0001_2345, 4'b0010);
        rd(5'h04, 32'h2302, "R13 strobe merge");
        wr(5'h0C, 32'h80); wr(5'h0C, 32'h86, 4'b0000); wr(5'h0C, 32'h86); wr(5'h04, 32'h2);
        rd(5'h04, 32'h2, "R13 strobeless write ignored");
        // R8: mode bit set keeps counting off
        wr(5'h10, 32'h6);
        idle(200);
        chk("R8 mode select quiet", {30'd0, irq, wrst}, 0);
        // R5/R6: full expiry with slow tick (16 clocks), pre1=3, pre2=2
        wr(5'h10, 32'h2);
        wait_irq(n);
        chk("R5 stage1 expiry cycle", n, 64);
        wait_rst(n);
        chk("R6 stage2 expiry cycle", n, 48);
        idle(1);
        chk("R6 single pulse", {31'd0, wrst}, 0);
        rd(5'h0C, 32'h200, "R6 flag set");
        // R11: clear pending
        wr(5'h08, 32'h1);
        rd(5'h08, 0, "R11 status cleared");
        // R7: clear needs the key
        wr(5'h0C, 32'h200);
        rd(5'h0C, 32'h200, "R7 ungated clear ignored");
        key(); wr(5'h0C, 32'h200);
        rd(5'h0C, 0, "R7 gated clear");
        // R4: keepalive holds off the interrupt
        for (int i = 0; i < 10; i++) begin
            key(); wr(5'h0C, 32'h100); idle(20);
        end
        chk("R4 keepalive no irq", {31'd0, irq}, 0);
        rd(5'h0C, 0, "R7 flag stays clear");
        for (int i = 0; i < 4; i++) begin
            wr(5'h0C, 32'h100); idle(20);
        end
        chk("R4 ungated reload ignored", {31'd0, irq}, 1);
        // R12: new preload applies at the next restart
        key(); wr(5'h00, 32'h0);
        rd(5'h00, 0, "R12 pre1 updated");
        key(); wr(5'h0C, 32'h100);
        wait_irq(n);
        chk("R12 new preload after restart", n, 16);
        // R10: fast tick, reset output off, interrupt type off
        wr(5'h14, 32'h27);
        key(); wr(5'h0C, 32'h300);
        rd(5'h0C, 0, "R7 clear with restart");
        idle(6);
        chk("R5 irq type off", {31'd0, irq}, 0);
        rd(5'h08, 1, "R5 status set with irq off");
        idle(12);
        rd(5'h0C, 32'h200, "R10 fast tick expiry");
        // R9: lock
        wr(5'h10, 32'h3);
        rd(5'h10, 32'h3, "R9 lock set");
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h3, "R9 ctrl locked");
        wr(5'h14, 32'h0);
        rd(5'h14, 32'h27, "R9 cfg locked");
        // power-on reset clears lock and flag
        rst_n = 0;
        idle(2);
        rst_n = 1;
        idle(1);
        rd(5'h10, 0, "R9 rst_n clears lock");
        rd(5'h0C, 0, "R7 rst_n clears flag");
        finish_run();
    end

endmodule